// File: doc/BRIEF.md
# IDE I/O Address Dispatcher

This block sits between a host I/O port and the register logic of a two-channel disk controller. Each host access carries an address, a byte count and, for writes, data. The block compares the address against five windows: a command window and a control window for each of the two channels, plus one shared window for the bus-master registers. It then issues a single-cycle strobe to the matching target, carrying a channel-local offset, the access size, the write flag, the write data and the drive currently selected on that channel.

Some address fixes are applied to the offset. Primary command offsets can be shifted right by a programmable amount, which undoes a host that spreads the registers out. Primary control offsets get a programmable constant added. The bus-master window is split between the channels at a fixed byte boundary.

The block watches writes to the drive-select register of each channel and keeps track of which of the two drives is selected. It also applies the I/O-enable and bus-master-enable bits of the host's command word. When a drive is absent, a read returns zero and a write is dropped. Every request receives exactly one response two cycles after it is sent. The response carries the read data and an error flag that marks a bad size or an address that hits no window.

Top module: `ide_io_dispatch`

## Requirements
- R1: An address hits a window when it is at or above the window base and its distance from the base is below the window span. Windows are tried in this order: primary command, primary control, secondary command, secondary control, bus master. The first hit wins. `tgtSel` encodes the target as follows: 0 primary command, 1 primary control, 2 secondary command, 3 secondary control, 4 primary bus-master, 5 secondary bus-master.
- R2: On a primary command hit, `tgtOffset` is (address − base) shifted right by `cmdShift`.
- R3: On a primary control hit, `tgtOffset` is (address − base) + `ctlAdd`. Secondary command and control offsets are the plain address − base.
- R4: In the bus-master window, local offsets below `BM_CH_BYTES` (default 8) go to target 4 unchanged. Offsets at or above it go to target 5 with `BM_CH_BYTES` subtracted.
- R5: While `pciCmd` bit 0 (I/O enable) is clear, no strobe is issued and the drive selection does not change. The response reports zero data and, for a valid size, no error.
- R6: While `pciCmd` bit 2 (bus-master enable) is clear, writes that hit the bus-master window produce no strobe. Reads of that window still produce a strobe.
- R7: A write whose command-window local offset (after the R2 shift) equals 6 selects drive 1 on that channel if data bit 4 is set, and drive 0 otherwise. The selection shows on `driveSel` (bit 0 primary, bit 1 secondary), and `tgtDrive` shows the selection of the accessed channel, including the update made by that same write.
- R8: The presence of a drive is given by `drivePresent` bit 2·channel+drive. A command or control access to a channel whose selected drive is absent produces no strobe and reads back zero. Bus-master accesses ignore presence.
- R9: `errFlag` is set in the response of a request whose size is not 1, 2 or 4. It is also set for a request with I/O enabled whose address hits no window. Erroneous requests produce no strobe and read back zero.
- R10: A request sampled at clock edge n gives its strobe in the cycle after edge n. The response (`rspValid`, `rspData`, `errFlag`) appears after edge n+2. `rspData` is the `tgtRdata` value present during a read strobe, and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Host I/O address |
| reqSize | input | 3 | Access size in bytes |
| reqData | input | DATA_W | Write data |
| pciCmd | input | 16 | Host command word; bit 0 I/O enable, bit 2 bus-master enable |
| priCmdBase | input | ADDR_W | Primary command window base |
| priCmdSpan | input | ADDR_W | Primary command window size |
| priCtlBase | input | ADDR_W | Primary control window base |
| priCtlSpan | input | ADDR_W | Primary control window size |
| secCmdBase | input | ADDR_W | Secondary command window base |
| secCmdSpan | input | ADDR_W | Secondary command window size |
| secCtlBase | input | ADDR_W | Secondary control window base |
| secCtlSpan | input | ADDR_W | Secondary control window size |
| bmBase | input | ADDR_W | Bus-master window base |
| bmSpan | input | ADDR_W | Bus-master window size |
| cmdShift | input | SHIFT_W | Right shift for primary command offsets |
| ctlAdd | input | ADDR_W | Constant added to primary control offsets |
| drivePresent | input | 4 | Drive present flags, bit 2·channel+drive |
| tgtRdata | input | DATA_W | Read data from the target during a strobe |
| tgtStrobe | output | 1 | One-cycle access strobe to a target |
| tgtSel | output | 3 | Target code (see R1) |
| tgtOffset | output | ADDR_W | Channel-local offset |
| tgtSize | output | 3 | Access size in bytes |
| tgtWrite | output | 1 | Write flag |
| tgtData | output | DATA_W | Write data |
| tgtDrive | output | 1 | Selected drive on the accessed channel |
| rspValid | output | 1 | Response strobe |
| rspData | output | DATA_W | Read data response |
| errFlag | output | 1 | Error flag, valid with rspValid |
| driveSel | output | 2 | Current drive selection per channel |

## Verification
A wrong drive selection first appears on the next command or control access to that channel. Either `tgtDrive` carries the wrong value, or the presence gate stops a strobe it should have let through (or the reverse), and the read then returns zero. Both effects show two or three cycles after the access. Errors in window priority or offset arithmetic show at once on `tgtSel` and `tgtOffset` in the strobe cycle. A wrongly set gating condition shows as a missing or extra strobe, or as a nonzero `rspData` where zero was due, one cycle later. The random mix changes the shift, the enable bits and the presence flags between accesses, so stale select state is exposed under different gates.

// File: rtl/ide_disp_pkg.sv
package ide_disp_pkg;

  localparam int WIN_COUNT  = 5;
  localparam int IO_EN_BIT  = 0;
  localparam int BM_EN_BIT  = 2;
  localparam int SEL_OFFSET = 6;
  localparam int SEL_BIT    = 4;

  typedef enum logic [2:0] {
    TGT_PRI_CMD = 3'd0,
    TGT_PRI_CTL = 3'd1,
    TGT_SEC_CMD = 3'd2,
    TGT_SEC_CTL = 3'd3,
    TGT_PRI_BM  = 3'd4,
    TGT_SEC_BM  = 3'd5,
    TGT_NONE    = 3'd7
  } tgt_e;

  // Strobes from control to datapath for the request in flight
  typedef struct packed {
    logic issue;  // forward the access to the target
    logic done;   // a request was sampled; respond two cycles later
    logic err;    // respond with error flag
    logic drive;  // drive selection of the accessed channel
  } ctrlStrobe_t;

endpackage

// File: rtl/ide_disp_window.sv
module ide_disp_window #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] span,
  output logic              hit,
  output logic [ADDR_W-1:0] localOff
);
  always_comb begin
    localOff = addr - base;
    hit      = (addr >= base) && (localOff < span);
  end
endmodule

// File: rtl/ide_disp_datapath.sv
module ide_disp_datapath
  import ide_disp_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int SHIFT_W     = 2,
  parameter int BM_CH_BYTES = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              reqWrite,
  input  logic [ADDR_W-1:0]                 reqAddr,
  input  logic [2:0]                        reqSize,
  input  logic [DATA_W-1:0]                 reqData,
  input  logic [WIN_COUNT-1:0][ADDR_W-1:0]  winBase,
  input  logic [WIN_COUNT-1:0][ADDR_W-1:0]  winSpan,
  input  logic [SHIFT_W-1:0]                cmdShift,
  input  logic [ADDR_W-1:0]                 ctlAdd,
  input  ctrlStrobe_t                       cs,
  input  logic [DATA_W-1:0]                 tgtRdata,
  output logic                              anyHit,
  output tgt_e                              candTgt,
  output logic                              candChan,
  output logic                              selWrite,
  output logic                              tgtStrobe,
  output logic [2:0]                        tgtSel,
  output logic [ADDR_W-1:0]                 tgtOffset,
  output logic [2:0]                        tgtSize,
  output logic                              tgtWrite,
  output logic [DATA_W-1:0]                 tgtData,
  output logic                              tgtDrive,
  output logic                              rspValid,
  output logic [DATA_W-1:0]                 rspData,
  output logic                              errFlag
);
  localparam int IDX_W = $clog2(WIN_COUNT);
  localparam logic [ADDR_W-1:0] BM_SPLIT = ADDR_W'(BM_CH_BYTES);
  localparam logic [ADDR_W-1:0] SEL_OFF  = ADDR_W'(SEL_OFFSET);

  logic [WIN_COUNT-1:0]             winHit;
  logic [WIN_COUNT-1:0][ADDR_W-1:0] winLocal;
  logic [IDX_W-1:0]                 winIdx;
  logic [ADDR_W-1:0]                candOff;
  logic                             rspPend;
  logic                             errPend;

  for (genvar g = 0; g < WIN_COUNT; g++) begin : gWin
    ide_disp_window #(.ADDR_W(ADDR_W)) uWin (
      .addr     (reqAddr),
      .base     (winBase[g]),
      .span     (winSpan[g]),
      .hit      (winHit[g]),
      .localOff (winLocal[g])
    );
  end

  // Lowest-numbered hitting window wins
  always_comb begin
    winIdx = '0;
    anyHit = |winHit;
    for (int i = WIN_COUNT - 1; i >= 0; i--) begin
      if (winHit[i]) winIdx = i[IDX_W-1:0];
    end
  end

  always_comb begin
    candTgt = TGT_NONE;
    candOff = '0;
    if (anyHit) begin
      case (winIdx)
        IDX_W'(0): begin
          candTgt = TGT_PRI_CMD;
          candOff = winLocal[0] >> cmdShift;
        end
        IDX_W'(1): begin
          candTgt = TGT_PRI_CTL;
          candOff = winLocal[1] + ctlAdd;
        end
        IDX_W'(2): begin
          candTgt = TGT_SEC_CMD;
          candOff = winLocal[2];
        end
        IDX_W'(3): begin
          candTgt = TGT_SEC_CTL;
          candOff = winLocal[3];
        end
        default: begin
          if (winLocal[4] < BM_SPLIT) begin
            candTgt = TGT_PRI_BM;
            candOff = winLocal[4];
          end else begin
            candTgt = TGT_SEC_BM;
            candOff = winLocal[4] - BM_SPLIT;
          end
        end
      endcase
    end
    candChan = (candTgt == TGT_SEC_CMD) || (candTgt == TGT_SEC_CTL) ||
               (candTgt == TGT_SEC_BM);
    selWrite = reqWrite && ((candTgt == TGT_PRI_CMD) || (candTgt == TGT_SEC_CMD)) &&
               (candOff == SEL_OFF);
  end

  // Strobe stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtStrobe <= 1'b0;
      tgtSel    <= '0;
      tgtOffset <= '0;
      tgtSize   <= '0;
      tgtWrite  <= 1'b0;
      tgtData   <= '0;
      tgtDrive  <= 1'b0;
      rspPend   <= 1'b0;
      errPend   <= 1'b0;
    end else begin
      tgtStrobe <= cs.issue;
      rspPend   <= cs.done;
      errPend   <= cs.err;
      if (cs.issue) begin
        tgtSel    <= candTgt;
        tgtOffset <= candOff;
        tgtSize   <= reqSize;
        tgtWrite  <= reqWrite;
        tgtData   <= reqData;
        tgtDrive  <= cs.drive;
      end
    end
  end

  // Response stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
      errFlag  <= 1'b0;
    end else begin
      rspValid <= rspPend;
      errFlag  <= errPend;
      rspData  <= (tgtStrobe && !tgtWrite) ? tgtRdata : '0;
    end
  end
endmodule

// File: rtl/ide_disp_ctrl.sv
module ide_disp_ctrl
  import ide_disp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [2:0]        reqSize,
  input  logic [DATA_W-1:0] reqData,
  input  logic [15:0]       pciCmd,
  input  logic [3:0]        drivePresent,
  input  logic              anyHit,
  input  tgt_e              candTgt,
  input  logic              candChan,
  input  logic              selWrite,
  output ctrlStrobe_t       cs,
  output logic [1:0]        driveSel
);
  logic       sizeOk;
  logic       ioEn;
  logic       bmEn;
  logic       accept;
  logic       isBm;
  logic       present;
  logic       bmBlocked;
  logic [1:0] nextSel;

  always_comb begin
    sizeOk    = (reqSize == 3'd1) || (reqSize == 3'd2) || (reqSize == 3'd4);
    ioEn      = pciCmd[IO_EN_BIT];
    bmEn      = pciCmd[BM_EN_BIT];
    accept    = reqValid && sizeOk && ioEn && anyHit;
    nextSel   = driveSel;
    if (accept && selWrite) nextSel[candChan] = reqData[SEL_BIT];
    isBm      = (candTgt == TGT_PRI_BM) || (candTgt == TGT_SEC_BM);
    present   = isBm || drivePresent[{candChan, nextSel[candChan]}];
    bmBlocked = isBm && reqWrite && !bmEn;
    cs.issue  = accept && present && !bmBlocked;
    cs.done   = reqValid;
    cs.err    = reqValid && (!sizeOk || (ioEn && !anyHit));
    cs.drive  = nextSel[candChan];
  end

  always_ff @(posedge clk) begin
    if (!rstN) driveSel <= 2'b00;
    else       driveSel <= nextSel;
  end
endmodule

// File: rtl/ide_io_dispatch.sv
module ide_io_dispatch
  import ide_disp_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int SHIFT_W     = 2,
  parameter int BM_CH_BYTES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqSize,
  input  logic [DATA_W-1:0] reqData,
  input  logic [15:0]       pciCmd,
  input  logic [ADDR_W-1:0] priCmdBase,
  input  logic [ADDR_W-1:0] priCmdSpan,
  input  logic [ADDR_W-1:0] priCtlBase,
  input  logic [ADDR_W-1:0] priCtlSpan,
  input  logic [ADDR_W-1:0] secCmdBase,
  input  logic [ADDR_W-1:0] secCmdSpan,
  input  logic [ADDR_W-1:0] secCtlBase,
  input  logic [ADDR_W-1:0] secCtlSpan,
  input  logic [ADDR_W-1:0] bmBase,
  input  logic [ADDR_W-1:0] bmSpan,
  input  logic [SHIFT_W-1:0] cmdShift,
  input  logic [ADDR_W-1:0] ctlAdd,
  input  logic [3:0]        drivePresent,
  input  logic [DATA_W-1:0] tgtRdata,
  output logic              tgtStrobe,
  output logic [2:0]        tgtSel,
  output logic [ADDR_W-1:0] tgtOffset,
  output logic [2:0]        tgtSize,
  output logic              tgtWrite,
  output logic [DATA_W-1:0] tgtData,
  output logic              tgtDrive,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              errFlag,
  output logic [1:0]        driveSel
);
  logic [WIN_COUNT-1:0][ADDR_W-1:0] winBase;
  logic [WIN_COUNT-1:0][ADDR_W-1:0] winSpan;
  ctrlStrobe_t cs;
  logic        anyHit;
  tgt_e        candTgt;
  logic        candChan;
  logic        selWrite;

  assign winBase = {bmBase, secCtlBase, secCmdBase, priCtlBase, priCmdBase};
  assign winSpan = {bmSpan, secCtlSpan, secCmdSpan, priCtlSpan, priCmdSpan};

  ide_disp_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SHIFT_W(SHIFT_W), .BM_CH_BYTES(BM_CH_BYTES)
  ) uDp (
    .clk(clk), .rstN(rstN),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqSize(reqSize), .reqData(reqData),
    .winBase(winBase), .winSpan(winSpan), .cmdShift(cmdShift), .ctlAdd(ctlAdd),
    .cs(cs), .tgtRdata(tgtRdata),
    .anyHit(anyHit), .candTgt(candTgt), .candChan(candChan), .selWrite(selWrite),
    .tgtStrobe(tgtStrobe), .tgtSel(tgtSel), .tgtOffset(tgtOffset), .tgtSize(tgtSize),
    .tgtWrite(tgtWrite), .tgtData(tgtData), .tgtDrive(tgtDrive),
    .rspValid(rspValid), .rspData(rspData), .errFlag(errFlag)
  );

  ide_disp_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqSize(reqSize), .reqData(reqData),
    .pciCmd(pciCmd), .drivePresent(drivePresent),
    .anyHit(anyHit), .candTgt(candTgt), .candChan(candChan), .selWrite(selWrite),
    .cs(cs), .driveSel(driveSel)
  );
endmodule

// File: rtl/ide_disp_checker.sv
module ide_disp_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [15:0]       pciCmd,
  input logic              tgtStrobe,
  input logic [2:0]        tgtSel,
  input logic              tgtWrite,
  input logic              rspValid,
  input logic [DATA_W-1:0] rspData,
  input logic              errFlag,
  input logic [1:0]        driveSel
);
  // R10
  strobe_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    tgtStrobe |-> $past(reqValid));
  // R10
  rsp_two_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid, 2));
  // R5
  strobe_needs_io_chk: assert property (@(posedge clk) disable iff (!rstN)
    tgtStrobe |-> $past(pciCmd[0]));
  // R6
  bm_write_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tgtStrobe && tgtWrite && (tgtSel >= 3'd4)) |-> $past(pciCmd[2]));
  // R9
  err_only_in_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (rspValid && (rspData == '0)));
  // R7
  select_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqWrite && pciCmd[0]) |=> $stable(driveSel));
  // R1
  target_code_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    tgtStrobe |-> (tgtSel <= 3'd5));
endmodule

bind ide_io_dispatch ide_disp_checker #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .pciCmd(pciCmd),
  .tgtStrobe(tgtStrobe), .tgtSel(tgtSel), .tgtWrite(tgtWrite),
  .rspValid(rspValid), .rspData(rspData), .errFlag(errFlag), .driveSel(driveSel)
);

// File: tb/ide_io_dispatch_test.sv
module ide_io_dispatch_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [2:0]  reqSize = 3'd1;
  logic [31:0] reqData = '0;
  logic [15:0] pciCmd = 16'h0005;
  logic [15:0] bBase [5];
  logic [15:0] bSpan [5];
  logic [1:0]  cmdShift = 2'd0;
  logic [15:0] ctlAdd = 16'd2;
  logic [3:0]  drivePresent = 4'hF;
  logic [31:0] tgtRdata = '0;
  logic        tgtStrobe, tgtWrite, tgtDrive, rspValid, errFlag;
  logic [2:0]  tgtSel, tgtSize;
  logic [15:0] tgtOffset;
  logic [31:0] tgtData, rspData;
  logic [1:0]  driveSel;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ide_io_dispatch uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqData(reqData), .pciCmd(pciCmd),
    .priCmdBase(bBase[0]), .priCmdSpan(bSpan[0]), .priCtlBase(bBase[1]), .priCtlSpan(bSpan[1]),
    .secCmdBase(bBase[2]), .secCmdSpan(bSpan[2]), .secCtlBase(bBase[3]), .secCtlSpan(bSpan[3]),
    .bmBase(bBase[4]), .bmSpan(bSpan[4]), .cmdShift(cmdShift), .ctlAdd(ctlAdd),
    .drivePresent(drivePresent), .tgtRdata(tgtRdata),
    .tgtStrobe(tgtStrobe), .tgtSel(tgtSel), .tgtOffset(tgtOffset), .tgtSize(tgtSize),
    .tgtWrite(tgtWrite), .tgtData(tgtData), .tgtDrive(tgtDrive),
    .rspValid(rspValid), .rspData(rspData), .errFlag(errFlag), .driveSel(driveSel)
  );

  // Reference model state and predictions
  logic [1:0]  mdlSel = 2'b00;
  bit          eStrobe, eErr, eDrv;
  logic [2:0]  eSel;
  logic [15:0] eOff;
  logic [31:0] eRd;
  string       gateTag, offTag;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic predict(input bit w, input logic [15:0] a, input logic [2:0] sz,
                         input logic [31:0] d, input logic [31:0] rd);
    bit sizeOk = (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    bit io = pciCmd[0];
    bit bm = pciCmd[2];
    int win = -1;
    int ch;
    bit isBm, present;
    logic [15:0] loc;
    for (int i = 0; i < 5; i++)
      if (win < 0 && a >= bBase[i] && (a - bBase[i]) < bSpan[i]) win = i;
    eSel = 3'd7; eOff = '0; offTag = "R1";
    if (win >= 0) begin
      loc = a - bBase[win];
      case (win)
        0: begin eSel = 3'd0; eOff = loc >> cmdShift; offTag = "R2"; end
        1: begin eSel = 3'd1; eOff = loc + ctlAdd;    offTag = "R3"; end
        2: begin eSel = 3'd2; eOff = loc;             offTag = "R3"; end
        3: begin eSel = 3'd3; eOff = loc;             offTag = "R3"; end
        default: begin
          offTag = "R4";
          if (loc < 16'd8) begin eSel = 3'd4; eOff = loc; end
          else begin eSel = 3'd5; eOff = loc - 16'd8; end
        end
      endcase
    end
    ch = (eSel == 3'd2 || eSel == 3'd3 || eSel == 3'd5) ? 1 : 0;
    if (sizeOk && io && win >= 0 && w && (eSel == 3'd0 || eSel == 3'd2) && eOff == 16'd6)
      mdlSel[ch] = d[4];
    isBm = (eSel == 3'd4 || eSel == 3'd5);
    present = isBm || drivePresent[2*ch + int'(mdlSel[ch])];
    eDrv = mdlSel[ch];
    eErr = !sizeOk || (io && win < 0);
    eStrobe = 1'b0;
    if (!sizeOk || (io && win < 0)) gateTag = "R9";
    else if (!io) gateTag = "R5";
    else if (isBm && w && !bm) gateTag = "R6";
    else if (!present) gateTag = "R8";
    else begin gateTag = "R10"; eStrobe = 1'b1; end
    eRd = (eStrobe && !w) ? rd : 32'h0;
  endtask

  task automatic access(input bit w, input logic [15:0] a, input logic [2:0] sz,
                        input logic [31:0] d);
    logic [31:0] rd = $urandom;
    @(negedge clk);
    predict(w, a, sz, d, rd);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqSize = sz; reqData = d; tgtRdata = rd;
    @(negedge clk);
    reqValid = 1'b0;
    chk(tgtStrobe == eStrobe, gateTag, "strobe", 32'(tgtStrobe), 32'(eStrobe));
    if (eStrobe && tgtStrobe) begin
      chk(tgtSel == eSel, "R1", "target", 32'(tgtSel), 32'(eSel));
      chk(tgtOffset == eOff, offTag, "offset", 32'(tgtOffset), 32'(eOff));
      chk(tgtDrive == eDrv, "R7", "drive", 32'(tgtDrive), 32'(eDrv));
      chk(tgtWrite == w && tgtSize == sz && tgtData == d, "R10", "fields",
          {tgtData[27:0], tgtWrite, tgtSize}, {d[27:0], w, sz});
    end
    @(negedge clk);
    chk(rspValid == 1'b1, "R10", "rspValid", 32'(rspValid), 32'd1);
    chk(rspData == eRd, gateTag, "rspData", rspData, eRd);
    chk(errFlag == eErr, "R9", "errFlag", 32'(errFlag), 32'(eErr));
    chk(driveSel == mdlSel, "R7", "driveSel", 32'(driveSel), 32'(mdlSel));
  endtask

  function automatic logic [2:0] pickSize();
    int r = $urandom % 10;
    if (r < 4) return 3'd1;
    if (r < 6) return 3'd2;
    if (r < 9) return 3'd4;
    return 3'(($urandom % 2 == 0) ? 3 : 6);
  endfunction

  initial begin
    void'($urandom(32'h1D3C_0A57));
    bBase[0] = 16'h01F0; bSpan[0] = 16'd32;
    bBase[1] = 16'h03F4; bSpan[1] = 16'd4;
    bBase[2] = 16'h0170; bSpan[2] = 16'd8;
    bBase[3] = 16'h0374; bSpan[3] = 16'd4;
    bBase[4] = 16'hC000; bSpan[4] = 16'd16;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state (R10, R7)
    chk(tgtStrobe == 1'b0 && rspValid == 1'b0, "R10", "reset outputs",
        {tgtStrobe, rspValid}, 32'd0);
    chk(driveSel == 2'b00, "R7", "reset driveSel", 32'(driveSel), 32'd0);

    // R2: shifted primary command offsets, select at shifted offset 6
    cmdShift = 2'd2;
    access(1'b0, 16'h01F0 + 16'd12, 3'd1, 0);
    access(1'b1, 16'h01F0 + 16'd24, 3'd1, 32'h10);   // R7 select drive 1
    access(1'b0, 16'h01F0 + 16'd4, 3'd2, 0);
    cmdShift = 2'd0;
    // R3: primary control with added constant, secondary plain
    access(1'b0, 16'h03F4 + 16'd1, 3'd1, 0);
    access(1'b1, 16'h0376, 3'd1, 32'hA5);
    // R8: primary drive 1 absent while selected
    drivePresent = 4'b1101;
    access(1'b0, 16'h01F2, 3'd1, 0);
    access(1'b1, 16'h01F6, 3'd1, 32'h00);            // R7 back to drive 0
    access(1'b0, 16'h01F2, 3'd1, 0);
    drivePresent = 4'hF;
    // R4: bus-master split boundary
    access(1'b0, 16'hC007, 3'd1, 0);
    access(1'b0, 16'hC008, 3'd1, 0);
    access(1'b1, 16'hC00C, 3'd4, 32'h1234_5678);
    // R6: bus-master writes dropped, reads proceed
    pciCmd = 16'h0001;
    access(1'b1, 16'hC002, 3'd1, 32'h01);
    access(1'b0, 16'hC002, 3'd1, 0);
    // R5: I/O disabled, select write ignored
    pciCmd = 16'h0004;
    access(1'b1, 16'h0176, 3'd1, 32'h10);
    access(1'b0, 16'h0170, 3'd1, 0);
    access(1'b0, 16'h9000, 3'd1, 0);
    pciCmd = 16'h0005;
    // R9: bad size, window end boundary miss
    access(1'b0, 16'h0170, 3'd3, 0);
    access(1'b0, 16'h03F8, 3'd1, 0);
    access(1'b0, 16'h03F7, 3'd1, 0);
    // R1: overlapping windows, lower-numbered wins
    bBase[2] = 16'h01F0;
    access(1'b0, 16'h01F3, 3'd1, 0);
    bBase[2] = 16'h0170;

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int r = $urandom % 6;
      logic [15:0] a;
      cmdShift = 2'($urandom % 3);
      pciCmd = ($urandom % 5 == 0) ? 16'(($urandom % 2) | (($urandom % 2) << 2)) : 16'h0005;
      drivePresent = ($urandom % 4 == 0) ? 4'($urandom) : 4'hF;
      if (r < 5) a = bBase[r] + 16'($urandom % bSpan[r]);
      else a = 16'h8000 + 16'($urandom % 256);
      if ((r == 0 || r == 2) && $urandom % 3 == 0)
        a = bBase[r] + ((r == 0) ? (16'd6 << cmdShift) : 16'd6);
      access(1'($urandom), a, pickSize(), $urandom);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL R10 watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule